// File: doc/BRIEF.md
# Accumulator-Ticked Periodic Pulse Generator

This block turns a fast input clock into a slower timer tick and derives periodic pulses from that tick, such as a one-pulse-per-second strobe. A 32-bit phase accumulator adds a programmable increment on every input clock. Each wrap of the accumulator is one timer tick. A fractional increment spreads the ticks unevenly over clocks while keeping their average rate exact.

Each pulse channel holds a down counter. On every tick the counter of an enabled channel drops by a programmable step, which is the nominal timer period per tick. When the counter reaches or passes zero, the channel emits a one-clock pulse. The counter is refilled from that channel's interval register on the following tick. That refill tick is part of the pulse spacing, so software programs the interval as the wanted period minus one step. For example, a step of 5 and a period of 1 s need an interval of 999999995.

All channels share one tick source and one step value. Each channel has its own interval and its own enable. Configuration uses a single-cycle write port. A registered tick output is also provided, so that downstream time-keeping logic can use the same tick.

Top module: `pulse_train_gen`

## Requirements
- R1: On every clock the 32-bit accumulator adds the increment register. Each carry out of that addition drives `tick_out` high for one clock, in the clock that follows the addition. Starting from a cleared accumulator with increment A, exactly floor(n*A/2^32) ticks appear over the first n additions.
- R2: On each tick, an enabled channel that is not waiting to refill lowers its counter by the step value.
- R3: The tick after the one that produced a pulse refills the counter from the interval register and does not decrement it. The spacing between successive pulses is therefore ceil(P/step)+1 ticks. When P = k*step - step, this spacing is k ticks.
- R4: A pulse is high for exactly one clock. It rises in the clock that follows the `tick_out` clock of the decrement that reached zero.
- R5: Each channel counts and pulses independently, with its own interval, while sharing the tick and the step.
- R6: When a decrement would take the counter below zero, the channel treats it as reaching zero and fires a pulse.
- R7: A disabled channel emits no pulse, and its counter does not move on ticks. Writing an interval register while its channel is disabled loads the counter at once. The first pulse after the channel is enabled then comes ceil(P/step) ticks later.
- R8: Writing an interval register while its channel is enabled does not alter the countdown in progress. The new value applies from the next refill.
- R9: A synchronous reset clears the accumulator, every register, every counter, `tick_out` and all pulses.
- R10: Write addresses: 0 is the increment, 1 is the step, 2 holds the enable bits (bit c enables channel c), and 3+c is the interval of channel c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (see R10) |
| wr_data | input | DATA_W | Write data |
| tick_out | output | 1 | One-clock timer tick, registered accumulator carry |
| pulse_out | output | NCH | One-clock periodic pulse per channel |

## Verification
The bench builds the block with its defaults: a 32-bit datapath and two channels. It drives an increment of 0xFFFFFFFF, which gives a tick on nearly every clock, so pulse spacing can be counted almost clock for clock. It also drives 0xAAAAAAAB, where ticks skip clocks, so spacing has to be counted in ticks rather than clocks. Intervals of 7 to 35 with steps of 4 and 5 keep every spacing within a few tens of clocks. With these values the bench can reach exact multiples of the step, non-multiples, the first pulse after a direct load, and an interval change made mid-count.

// File: rtl/pt_pkg.sv
package pt_pkg;
  // Register map; channel intervals start at ADDR_PER_BASE, one per channel
  localparam int ADDR_INCR     = 0;
  localparam int ADDR_STEP     = 1;
  localparam int ADDR_ENABLE   = 2;
  localparam int ADDR_PER_BASE = 3;
endpackage

// File: rtl/pt_regs.sv
module pt_regs #(
  parameter int DATA_W = 32,
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            incr,
  output logic [DATA_W-1:0]            step,
  output logic [NCH-1:0]               chan_en,
  output logic [NCH-1:0][DATA_W-1:0]   interval,
  output logic [NCH-1:0]               direct_ld
);
  import pt_pkg::*;

  localparam logic [ADDR_W-1:0] A_INCR = ADDR_W'(ADDR_INCR);
  localparam logic [ADDR_W-1:0] A_STEP = ADDR_W'(ADDR_STEP);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(ADDR_ENABLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      incr    <= '0;
      step    <= '0;
      chan_en <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_INCR) incr    <= wr_data;
      if (wr_addr == A_STEP) step    <= wr_data;
      if (wr_addr == A_EN)   chan_en <= wr_data[NCH-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_per
    localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(ADDR_PER_BASE + c);
    logic hit;
    assign hit = wr_en && (wr_addr == A_PER);
    // a write to a stopped channel also presets its counter
    assign direct_ld[c] = hit && !chan_en[c];

    always_ff @(posedge clk) begin
      if (rst)      interval[c] <= '0;
      else if (hit) interval[c] <= wr_data;
    end
  end
endmodule

// File: rtl/pt_accum.sv
module pt_accum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] incr,
  output logic         tick
);
  // returns {carry, sum}
  function automatic logic [W:0] phase_add(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [W-1:0] acc_q;
  logic [W:0]   acc_nxt;
  logic         carry;
  logic         past_ok;

  assign acc_nxt = phase_add(acc_q, incr);
  assign carry   = acc_nxt[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      tick    <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      acc_q   <= acc_nxt[W-1:0];
      tick    <= carry;
      past_ok <= 1'b1;
    end
  end

  // R1: a tick marks exactly the additions that wrapped the phase
  a_r1_tick_is_wrap: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (tick == (acc_q < $past(acc_q))));
endmodule

// File: rtl/pt_chan.sv
module pt_chan #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         en,
  input  logic [W-1:0] step,
  input  logic [W-1:0] interval,
  input  logic         direct_ld,
  input  logic [W-1:0] ld_val,
  output logic         pulse
);
  // returns {hit_zero, remaining}; a step past zero counts as zero
  function automatic logic [W:0] count_down(input logic [W-1:0] cnt, input logic [W-1:0] stp);
    if (cnt <= stp) return {1'b1, {W{1'b0}}};
    return {1'b0, cnt - stp};
  endfunction

  logic [W-1:0] cnt_q;
  logic         refill_q;
  logic [W:0]   dn;
  logic         advance, refill_ev, dec_ev, zero_ev;

  assign dn        = count_down(cnt_q, step);
  assign advance   = tick && en;
  assign refill_ev = advance && refill_q;
  assign dec_ev    = advance && !refill_q;
  assign zero_ev   = dec_ev && dn[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      refill_q <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      pulse <= zero_ev;
      if (direct_ld) begin
        cnt_q    <= ld_val;
        refill_q <= 1'b0;
      end else if (refill_ev) begin
        cnt_q    <= interval;
        refill_q <= 1'b0;
      end else if (dec_ev) begin
        cnt_q    <= dn[W-1:0];
        refill_q <= dn[W];
      end
    end
  end

  // R4: pulse lasts one clock
  a_r4_one_clock: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  // R2 / R6: a pulse is only ever seen with an emptied counter awaiting refill
  a_r2_empty_at_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (cnt_q == '0 && refill_q));
  // R7: a stopped channel stays quiet
  a_r7_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pulse);
  // R7: a direct load lands in the counter
  a_r7_direct_load: assert property (@(posedge clk) disable iff (rst)
    direct_ld |=> (cnt_q == $past(ld_val) && !refill_q));
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int DATA_W = 32,
  parameter int NCH    = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tick_out,
  output logic [NCH-1:0]    pulse_out
);
  logic [DATA_W-1:0]          incr, step;
  logic [NCH-1:0]             chan_en, direct_ld;
  logic [NCH-1:0][DATA_W-1:0] interval;
  logic                       tick;

  pt_regs #(.DATA_W(DATA_W), .NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .incr(incr), .step(step), .chan_en(chan_en), .interval(interval),
    .direct_ld(direct_ld)
  );

  pt_accum #(.W(DATA_W)) u_acc (
    .clk(clk), .rst(rst), .incr(incr), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pt_chan #(.W(DATA_W)) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .en(chan_en[c]), .step(step),
      .interval(interval[c]), .direct_ld(direct_ld[c]), .ld_val(wr_data),
      .pulse(pulse_out[c])
    );
  end

  assign tick_out = tick;

  // R9: reset leaves every output low
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (pulse_out == '0 && !tick_out));
  // R4: a pulse always follows a tick
  a_r4_after_tick: assert property (@(posedge clk) disable iff (rst)
    (pulse_out != '0) |-> $past(tick_out));
endmodule

// File: tb/sim_pulse_train_gen.sv
module sim_pulse_train_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        tick_out;
  logic [1:0]  pulse_out;

  always #4 clk = ~clk; // 125 MHz

  pulse_train_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_out(tick_out), .pulse_out(pulse_out)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // pulse monitor: spacing counted in ticks
  int   pcount [2];
  int   last_sp [2];
  int   tick_acc [2];
  bit   clr [2];
  logic tick_prev = 1'b0;
  logic [1:0] pulse_prev = '0;
  int   wide_err = 0, lat_err = 0;

  initial for (int c = 0; c < 2; c++) begin
    pcount[c] = 0; last_sp[c] = 0; tick_acc[c] = 0; clr[c] = 0;
  end

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (clr[c]) begin tick_acc[c] = 0; clr[c] = 0; end
      tick_acc[c] += int'(tick_prev);
      if (pulse_out[c]) begin
        if (pulse_prev[c]) wide_err++;
        if (!tick_prev) lat_err++;
        last_sp[c] = tick_acc[c];
        tick_acc[c] = 0;
        pcount[c]++;
      end
    end
    tick_prev  = tick_out;
    pulse_prev = pulse_out;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // stop, preset both counters, enable per mask, restart tick counting
  task automatic start_ch(input logic [1:0] mask, input int p0, input int p1);
    write_reg(2, 32'd0);
    write_reg(3, 32'(p0));
    write_reg(4, 32'(p1));
    write_reg(2, {30'd0, mask});
    @(posedge clk);
    clr[0] = 1; clr[1] = 1;
  endtask

  task automatic expect_gap(input int ch, input int exp, input string req);
    int start = pcount[ch];
    int n = 0;
    while (pcount[ch] == start && n < 400) begin @(posedge clk); n++; end
    if (n >= 400) check(0, {req, " timeout"}, 0, exp);
    else          check(last_sp[ch] == exp, req, last_sp[ch], exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(pulse_out == 2'b00, "R9 pulses after reset", pulse_out, 0);
    check(tick_out == 1'b0, "R9 tick after reset", tick_out, 0);
  endtask

  task automatic t_tick_rate;
    longint a = 64'h0000_0000_AAAA_AAAB;
    longint exp = (300 * a) >> 32;
    int cnt = 0;
    write_reg(0, 32'hAAAA_AAAB); // R10 increment address 0
    repeat (300) begin @(negedge clk); cnt += int'(tick_out); end
    check(cnt == exp, "R1 R10 tick count", cnt, exp);
  endtask

  task automatic t_frac;
    write_reg(1, 32'd5);
    start_ch(2'b01, 15, 0);
    expect_gap(0, 3, "R7 first pulse after direct load");
    for (int i = 0; i < 3; i++) expect_gap(0, 4, "R3 fractional-tick spacing");
  endtask

  task automatic t_dual;
    write_reg(0, 32'hFFFF_FFFF);
    start_ch(2'b11, 15, 25);
    expect_gap(0, 3, "R7 ch0 first pulse");
    expect_gap(0, 4, "R2 ch0 spacing");
    expect_gap(0, 4, "R2 ch0 spacing");
    expect_gap(1, 6, "R5 R10 ch1 spacing");
    expect_gap(1, 6, "R5 ch1 spacing");
    expect_gap(0, 4, "R5 ch0 unaffected by ch1");
    check(wide_err == 0, "R4 pulse width", wide_err, 0);
    check(lat_err == 0, "R4 pulse follows tick", lat_err, 0);
  endtask

  task automatic t_nonmult;
    start_ch(2'b01, 7, 0);
    expect_gap(0, 2, "R6 first pulse past zero");
    expect_gap(0, 3, "R6 spacing non-multiple");
    write_reg(1, 32'd4);
    start_ch(2'b01, 10, 0);
    expect_gap(0, 3, "R6 step4 first pulse");
    expect_gap(0, 4, "R6 step4 spacing");
    write_reg(1, 32'd5);
  endtask

  task automatic t_idle;
    int s;
    write_reg(2, 32'd0);
    repeat (3) @(negedge clk);
    s = pcount[0] + pcount[1];
    repeat (40) @(negedge clk);
    check(pcount[0] + pcount[1] == s, "R7 no pulse while stopped", pcount[0] + pcount[1], s);
    check(pulse_out == 2'b00, "R7 outputs low while stopped", pulse_out, 0);
  endtask

  task automatic t_live;
    start_ch(2'b01, 15, 0);
    expect_gap(0, 3, "R8 setup first pulse");
    write_reg(3, 32'd35); // mid-count change while enabled
    expect_gap(0, 4, "R8 current interval kept");
    expect_gap(0, 8, "R8 new interval applied");
    expect_gap(0, 8, "R8 new interval held");
  endtask

  task automatic t_reset_mid;
    int tk = 0, pc = 0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(pulse_out == 2'b00, "R9 pulses in reset", pulse_out, 0);
    check(tick_out == 1'b0, "R9 tick in reset", tick_out, 0);
    @(negedge clk); rst = 1'b0;
    repeat (30) begin
      @(negedge clk);
      tk += int'(tick_out);
      pc += int'(pulse_out != 2'b00);
    end
    check(tk == 0, "R9 increment cleared", tk, 0);
    check(pc == 0, "R9 channels cleared", pc, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_tick_rate();
    t_frac();
    t_dual();
    t_nonmult();
    t_idle();
    t_live();
    t_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule